// File: doc/BRIEF.md
# Source-Selecting Fractional Clock-Enable Divider

This block picks one of several clock-enable pulse streams and thins it by a programmable ratio that has an integer and a fractional part. Its single output pulse stream drives one downstream peripheral. The design is fully synchronous: every input "clock" is a one-cycle enable pulse in the system clock domain, and the output is a registered enable pulse of the same kind.

Software-visible state is presented as plain configuration ports: an enable flag, a source index and a 32-bit divider word. A busy flag reports the enable state back. The integer and fractional widths are per-instance parameters. The integer field always starts at bit 12 of the divider word, and the fractional field sits directly below it.

Division uses a first-order phase accumulator. Each selected pulse adds one unit (2^FRAC_BITS). When the running sum reaches the divisor, an output pulse is produced and the divisor is subtracted. When both widths are zero the block becomes a plain registered pass-through. A new source or divisor is copied into the active settings only while the block is disabled, or on the cycle that produces an output pulse, so no runt pulse can appear.

Top module: `frac_clk_div`

## Requirements
- R1: While `cfg_enable` is low at a clock edge, `tick_out` is low after that edge and the accumulator restarts from zero.
- R2: `busy` is low after reset, and after every other edge it equals the value `cfg_enable` had at that edge.
- R3: Source index 0 is a ground and never produces a pulse. Any index at or above NUM_SRC also reads as ground. Any other index k passes the pulses of `src_tick[k]` only; pulses on the other inputs have no effect.
- R4: The divisor is `cfg_div[12+INT_BITS-1 : 12-FRAC_BITS]`, read as an unsigned integer. Bits outside this field are ignored. With the defaults it is bits 15:8: bits 15:12 hold the integer part and bits 11:8 the fraction in sixteenths.
- R5: Starting from a cleared accumulator and a divisor D ≥ 2^FRAC_BITS, N selected pulses give exactly floor(N·2^FRAC_BITS / D) output pulses. An output pulse occurs on the selected pulse that brings the sum to D or above.
- R6: A divisor of zero stops the output completely.
- R7: A nonzero divisor below 2^FRAC_BITS (a ratio below one) passes every selected pulse.
- R8: With INT_BITS = FRAC_BITS = 0, every selected pulse passes with no division.
- R9: While enabled, changes to `cfg_src` and `cfg_div` take effect only at the edge that emits an output pulse. While disabled, they are taken at every edge.
- R10: An output pulse appears in the cycle after the edge at which the triggering source pulse was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enable flag of the control setting |
| cfg_src | input | SEL_W | Source index of the control setting |
| cfg_div | input | DIV_REG_W | Divider word; the integer part is anchored at bit 12 |
| src_tick | input | NUM_SRC | Input clock-enable pulse streams; bit 0 is never used |
| busy | output | 1 | Registered copy of the enable flag |
| tick_out | output | 1 | Registered output clock-enable pulse |

## Verification
Two events can coincide. The first is the reload of the active source and divisor, which lands on the same edge as the output pulse that the accumulator emits with the old divisor. The bench provokes this by rewriting `cfg_div` and `cfg_src` mid-run while pulses keep arriving. It then checks that the old settings still govern that pulse and the new ones govern every later one. The second is a clear of `cfg_enable` on the cycle where a pulse would have fired. The bench expects no pulse there, and a fresh phase on re-enable.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // Bit position where the integer part of the divisor starts
  localparam int ANCHOR_BIT = 12;
endpackage

// File: rtl/cdiv_src_pick.sv
module cdiv_src_pick #(
  parameter int NUM_SRC = 10,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               picked
);
  // Index 0 is ground; its input bit is never routed
  logic unused_gnd;
  assign unused_gnd = src_tick[0];

  always_comb begin
    picked = 1'b0;
    for (int k = 1; k < NUM_SRC; k++) begin
      if (sel == SEL_W'(k)) picked = src_tick[k];
    end
  end
endmodule

// File: rtl/cdiv_shadow.sv
module cdiv_shadow #(
  parameter int SEL_W     = 4,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4,
  parameter int DIV_REG_W = 32,
  parameter int ANCHOR    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_enable,
  input  logic [SEL_W-1:0]     cfg_src,
  input  logic [DIV_REG_W-1:0] cfg_div,
  input  logic                 reload,
  output logic [SEL_W-1:0]     act_src,
  output logic [((INT_BITS+FRAC_BITS)==0 ? 1 : INT_BITS+FRAC_BITS)-1:0] act_div,
  output logic                 busy
);
  localparam int W   = INT_BITS + FRAC_BITS;
  localparam int DW  = (W == 0) ? 1 : W;
  localparam int LSB = ANCHOR - FRAC_BITS;

  logic [DW-1:0] new_div;
  logic          unused_div;
  assign unused_div = ^cfg_div;

  generate
    if (W == 0) begin : g_nodiv
      assign new_div = '0;
    end else begin : g_field
      assign new_div = cfg_div[LSB +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      act_src <= '0;
      act_div <= '0;
      busy    <= 1'b0;
    end else begin
      busy <= cfg_enable;
      if (!cfg_enable || reload) begin
        act_src <= cfg_src;
        act_div <= new_div;
      end
    end
  end

  // R2
  busy_on_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_enable |=> busy);
  // R2
  busy_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !busy);
  // R9
  settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_enable && !reload) |=> ($stable(act_div) && $stable(act_src)));
endmodule

// File: rtl/cdiv_frac_acc.sv
module cdiv_frac_acc #(
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic in_tick,
  input  logic [((INT_BITS+FRAC_BITS)==0 ? 1 : INT_BITS+FRAC_BITS)-1:0] div,
  output logic fire,
  output logic tick_out
);
  localparam int W  = INT_BITS + FRAC_BITS;
  localparam int DW = (W == 0) ? 1 : W;

  generate
    if (W == 0) begin : g_bypass
      logic unused_div;
      assign unused_div = ^div;
      assign fire = enable & in_tick;
      always_ff @(posedge clk) begin
        if (rst) tick_out <= 1'b0;
        else     tick_out <= fire;
      end
    end else begin : g_accum
      localparam logic [DW:0] ONE = (DW+1)'(1) << FRAC_BITS;
      logic [DW-1:0] acc;
      logic [DW:0]   sum, rem, div_x;
      logic          div_ok;

      assign div_x  = {1'b0, div};
      assign div_ok = (div != '0);
      assign sum    = {1'b0, acc} + ONE;
      assign rem    = sum - div_x;
      assign fire   = enable & in_tick & div_ok & (sum >= div_x);

      always_ff @(posedge clk) begin
        if (rst) begin
          acc      <= '0;
          tick_out <= 1'b0;
        end else if (!enable) begin
          acc      <= '0;
          tick_out <= 1'b0;
        end else begin
          tick_out <= fire;
          if (in_tick && div_ok) begin
            if (fire) acc <= (rem >= div_x) ? '0 : rem[DW-1:0];
            else      acc <= sum[DW-1:0];
          end
        end
      end

      // R6
      zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |=> !tick_out);
      // R10
      pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(in_tick));
    end
  endgenerate
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import cdiv_pkg::*;
#(
  parameter int NUM_SRC   = 10,
  parameter int SEL_W     = 4,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4,
  parameter int DIV_REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_enable,
  input  logic [SEL_W-1:0]     cfg_src,
  input  logic [DIV_REG_W-1:0] cfg_div,
  input  logic [NUM_SRC-1:0]   src_tick,
  output logic                 busy,
  output logic                 tick_out
);
  localparam int W  = INT_BITS + FRAC_BITS;
  localparam int DW = (W == 0) ? 1 : W;

  logic [SEL_W-1:0] act_src;
  logic [DW-1:0]    act_div;
  logic             picked;
  logic             fire;

  cdiv_shadow #(
    .SEL_W(SEL_W), .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS),
    .DIV_REG_W(DIV_REG_W), .ANCHOR(ANCHOR_BIT)
  ) u_shadow (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
    .cfg_div(cfg_div), .reload(fire), .act_src(act_src),
    .act_div(act_div), .busy(busy)
  );

  cdiv_src_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick (
    .src_tick(src_tick), .sel(act_src), .picked(picked)
  );

  cdiv_frac_acc #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_acc (
    .clk(clk), .rst(rst), .enable(cfg_enable), .in_tick(picked),
    .div(act_div), .fire(fire), .tick_out(tick_out)
  );

  // R1
  stop_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !tick_out);
  // R3
  ground_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((act_src == '0) || (int'(act_src) >= NUM_SRC)) |=> !tick_out);
endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  localparam int NSRC = 10;
  localparam int IB   = 4;
  localparam int FB   = 4;
  localparam int ONE  = 1 << FB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        en;
  logic [3:0]  src;
  logic [31:0] divr;
  logic [9:0]  tk;
  logic busy, tick, busy_b, tick_b;

  frac_clk_div #(.NUM_SRC(NSRC), .SEL_W(4), .INT_BITS(IB), .FRAC_BITS(FB),
    .DIV_REG_W(32)) u_frac_clk_div (
    .clk(clk), .rst(rst), .cfg_enable(en), .cfg_src(src), .cfg_div(divr),
    .src_tick(tk), .busy(busy), .tick_out(tick));

  frac_clk_div #(.NUM_SRC(NSRC), .SEL_W(4), .INT_BITS(0), .FRAC_BITS(0),
    .DIV_REG_W(32)) u_frac_clk_div_byp (
    .clk(clk), .rst(rst), .cfg_enable(en), .cfg_src(src), .cfg_div(divr),
    .src_tick(tk), .busy(busy_b), .tick_out(tick_b));

  int checks = 0, errors = 0, seen = 0, seen_b = 0, base = 0, base_b = 0;
  bit qt[$];
  bit qb[$];
  bit qtb[$];
  string qtag[$];
  int m_src = 0, m_div = 0, m_acc = 0, mb_src = 0;

  function automatic int field(int r);
    return (r >> (12 - FB)) & ((1 << (IB + FB)) - 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes the expected result
  task automatic step(bit e, int s, int d, logic [9:0] m, string tag);
    bit et, etb, t, tb;
    int sum, rem;
    et = 0; etb = 0;
    @(negedge clk);
    en = e; src = s[3:0]; divr = d; tk = m;
    if (!e) begin
      m_acc = 0; m_src = s; m_div = field(d); mb_src = s;
    end else begin
      t = (m_src > 0 && m_src < NSRC) ? m[m_src] : 1'b0;
      if (t && m_div != 0) begin
        sum = m_acc + ONE;
        if (sum >= m_div) begin
          et = 1;
          rem = sum - m_div;
          m_acc = (rem >= m_div) ? 0 : rem;
          m_src = s; m_div = field(d);
        end else m_acc = sum;
      end
      tb = (mb_src > 0 && mb_src < NSRC) ? m[mb_src] : 1'b0;
      if (tb) begin etb = 1; mb_src = s; end
    end
    qt.push_back(et); qb.push_back(e); qtb.push_back(etb); qtag.push_back(tag);
  endtask

  task automatic run(bit e, int s, int d, logic [9:0] m, int n, string tag);
    for (int i = 0; i < n; i++) step(e, s, d, m, tag);
  endtask

  task automatic cnt_begin();
    base = seen; base_b = seen_b;
  endtask

  task automatic cnt_end(string tag, int exp, bit byp);
    @(posedge clk); #3;
    if (byp) chk(tag, seen_b - base_b, exp);
    else     chk(tag, seen - base, exp);
  endtask

  // Monitor: pops expected items and compares after each edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (qt.size() > 0) begin
        bit et, eb, etb;
        string tg;
        et = qt.pop_front(); eb = qb.pop_front();
        etb = qtb.pop_front(); tg = qtag.pop_front();
        seen += int'(tick); seen_b += int'(tick_b);
        chk({tg, " tick"}, int'(tick), int'(et));
        chk({tg, " busy R2"}, int'(busy), int'(eb));
        chk({tg, " bypass R8"}, int'(tick_b), int'(etb));
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [9:0] M1  = 10'b00_0000_0010;
  localparam logic [9:0] M9  = 10'b10_0000_0000;
  localparam logic [9:0] ALL = 10'b11_1111_1111;

  initial begin
    en = 0; src = 0; divr = 0; tk = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("reset tick R1", int'(tick), 0);
    chk("reset busy R2", int'(busy), 0);
    @(negedge clk); rst = 0;

    // R5: divide by 2.0
    run(0, 1, 32'h2000, 0, 1, "R5 load");
    cnt_begin(); run(1, 1, 32'h2000, M1, 20, "R5 div2.0"); cnt_end("R5 div2.0 count", 10, 0);
    // R5: divide by 2.5
    run(0, 1, 32'h2800, 0, 1, "R5 load");
    cnt_begin(); run(1, 1, 32'h2800, M1, 20, "R5 div2.5"); cnt_end("R5 div2.5 count", 8, 0);
    // R3/R10: highest input, divide by 1.0
    run(0, 9, 32'h1000, 0, 1, "R3 load");
    cnt_begin(); run(1, 9, 32'h1000, M9, 6, "R10 src9"); cnt_end("R3 src9 count", 6, 0);
    // R3: pulses on unselected inputs ignored
    run(0, 1, 32'h1000, 0, 1, "R3 load");
    cnt_begin(); run(1, 1, 32'h1000, ALL & ~M1, 6, "R3 others"); cnt_end("R3 others count", 0, 0);
    // R3: ground index and out-of-range index
    run(0, 0, 32'h1000, 0, 1, "R3 load");
    cnt_begin(); run(1, 0, 32'h1000, ALL, 5, "R3 src0"); cnt_end("R3 src0 count", 0, 0);
    run(0, 12, 32'h1000, 0, 1, "R3 load");
    cnt_begin(); run(1, 12, 32'h1000, ALL, 5, "R3 src12"); cnt_end("R3 src12 count", 0, 0);
    // R4/R6: bits only outside the field give a zero divisor
    run(0, 1, 32'h0001_0080, 0, 1, "R4 load");
    cnt_begin(); run(1, 1, 32'h0001_0080, M1, 8, "R4 outside"); cnt_end("R4 outside count", 0, 0);
    run(0, 1, 0, 0, 1, "R6 load");
    cnt_begin(); run(1, 1, 0, M1, 8, "R6 zero"); cnt_end("R6 zero count", 0, 0);
    // R7: ratio below one
    run(0, 1, 32'h0800, 0, 1, "R7 load");
    cnt_begin(); run(1, 1, 32'h0800, M1, 10, "R7 div0.5"); cnt_end("R7 div0.5 count", 10, 0);
    // R4: full field with junk around it = 255
    run(0, 1, 32'hFFFF_FFFF, 0, 1, "R4 load");
    cnt_begin(); run(1, 1, 32'hFFFF_FFFF, M1, 255, "R4 full"); cnt_end("R4 full count", 16, 0);
    // R9: divisor change while enabled waits for the next pulse
    run(0, 1, 32'h4000, 0, 1, "R9 load");
    cnt_begin(); run(1, 1, 32'h4000, M1, 2, "R9 pre");
    run(1, 1, 32'h1000, M1, 6, "R9 newdiv"); cnt_end("R9 div swap count", 5, 0);
    cnt_begin(); run(1, 2, 32'h1000, M1, 3, "R9 newsrc"); cnt_end("R9 src swap count", 1, 0);
    // R1: disable stops output and clears phase
    run(0, 1, 32'h1000, 0, 1, "R1 load");
    cnt_begin(); run(0, 1, 32'h1000, M1, 4, "R1 off"); cnt_end("R1 off count", 0, 0);
    run(0, 1, 32'h2000, 0, 1, "R1 load");
    cnt_begin();
    step(1, 1, 32'h2000, M1, "R1 half");
    step(0, 1, 32'h2000, M1, "R1 drop");
    step(1, 1, 32'h2000, M1, "R1 restart");
    cnt_end("R1 phase cleared count", 0, 0);
    // R8: bypass instance passes every selected pulse
    run(0, 1, 32'h2000, 0, 1, "R8 load");
    cnt_begin(); run(1, 1, 32'h2000, M1, 5, "R8 pass"); cnt_end("R8 bypass count", 5, 1);
    run(0, 1, 32'h2000, 0, 2, "R2 idle");
    @(posedge clk); #3;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule